// File: doc/BRIEF.md
# 24-bit Pixel Fill Engine

The block fills a byte-addressed framebuffer that holds three bytes per pixel with one constant colour. A one-cycle start pulse captures a start address, a pixel count, a row stride and a 24-bit colour. It also captures a mode select that picks one of two layouts. In row mode the pixels form a contiguous run. In column mode the engine writes one pixel per display row, so it draws a vertical line. Each successive pixel base then lies three times the stride further on, where the stride is the display width in pixels.

Every pixel leaves as three single-byte writes on a valid/ready port, most significant colour byte first at the lowest address. The engine keeps its own copy of every job input. The source may therefore change its inputs as soon as the start pulse has been taken. When the last byte has been accepted, a one-cycle done pulse tells the source that it may launch the next fill.

Top module: `pixel_fill_engine`

## Requirements
- R1: In row mode (`mode_i` = 0), byte k (k = 0, 1, 2) of pixel n is written at address `base + 3n + k`, reduced modulo 2^ADDR_W.
- R2: Byte k = 0 of every pixel carries colour bits 23..16, k = 1 carries bits 15..8, and k = 2 carries bits 7..0.
- R3: In column mode (`mode_i` = 1), byte k of pixel n is written at address `base + 3*stride*n + k`, reduced modulo 2^ADDR_W. The stride input has no effect in row mode.
- R4: A job with pixel count c produces exactly 3c accepted byte writes, in order of increasing n and then k, and `wr_valid_o` stays low once the last one has been accepted.
- R5: A start with pixel count 0 writes nothing and raises `done_o` in the cycle after the start.
- R6: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` hold their values into the next cycle.
- R7: A start pulse while `busy_o` is high is ignored, and job inputs that change after an accepted start do not affect the running job.
- R8: `done_o` is high for exactly one cycle, the cycle after the last byte is accepted, and `busy_o` is low in that cycle.
- R9: After reset `wr_valid_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches a job when the engine is idle |
| mode_i | input | 1 | 0 = row (contiguous) fill, 1 = column fill |
| base_addr_i | input | ADDR_W | Byte address of the first pixel |
| pix_count_i | input | CNT_W | Number of pixels to write |
| stride_i | input | STRIDE_W | Row pitch in pixels (column mode) |
| color_i | input | 24 | Fill colour |
| wr_valid_o | output | 1 | Byte write request |
| wr_ready_i | input | 1 | Memory accepts the byte in this cycle |
| wr_addr_o | output | ADDR_W | Byte write address |
| wr_data_o | output | 8 | Byte write data |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first byte of a job is requested in the cycle after the start edge. The bench samples every output at the falling edge and treats a byte as written when valid and its own ready are both high for the next rising edge. Done is due at the first falling edge after the edge that accepts the last byte, or at the first falling edge after a zero-count start. The bench checks that edge, and the one after it, for the pulse and its end. Expected addresses and bytes come from the pixel and lane indices by plain arithmetic. A held request is compared against the values sampled one cycle earlier.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

  typedef enum logic {
    FILL_ROW = 1'b0,
    FILL_COL = 1'b1
  } fill_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fill_state_e;

  localparam int LANES = 3;

  // Distance between the base addresses of consecutive pixels
  function automatic logic [31:0] pixel_step(input logic mode, input logic [31:0] stride);
    logic [31:0] s;
    if (mode == FILL_COL) s = stride * 32'd3;
    else                  s = 32'd3;
    return s;
  endfunction

  // Colour byte for a lane; lane 0 is the most significant byte
  function automatic logic [7:0] color_lane(input logic [23:0] c, input logic [1:0] lane);
    logic [7:0] b;
    case (lane)
      2'd0:    b = c[23:16];
      2'd1:    b = c[15:8];
      default: b = c[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/pfe_ctrl.sv
module pfe_ctrl
  import pfe_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ready_i,
  output logic             busy_o,
  output logic             launch_o,
  output logic             zero_start_o,
  output logic             accept_o,
  output logic             pixel_adv_o,
  output logic             last_accept_o,
  output logic [1:0]       lane_o,
  output logic             done_o
);

  localparam logic [1:0] LAST_LANE = 2'(LANES - 1);

  fill_state_e      state_q;
  logic [CNT_W-1:0] remain_q;
  logic [1:0]       lane_q;
  logic             done_q;

  logic idle;
  assign idle          = (state_q == ST_IDLE);
  assign launch_o      = start_i && idle && (count_i != '0);
  assign zero_start_o  = start_i && idle && (count_i == '0);
  assign accept_o      = (state_q == ST_RUN) && ready_i;
  assign pixel_adv_o   = accept_o && (lane_q == LAST_LANE);
  assign last_accept_o = pixel_adv_o && (remain_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      lane_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= zero_start_o || last_accept_o;
      if (launch_o) begin
        state_q  <= ST_RUN;
        remain_q <= count_i;
        lane_q   <= '0;
      end else if (accept_o) begin
        if (lane_q == LAST_LANE) begin
          lane_q   <= '0;
          remain_q <= remain_q - CNT_W'(1);
          if (remain_q == CNT_W'(1)) state_q <= ST_IDLE;
        end else begin
          lane_q <= lane_q + 2'd1;
        end
      end
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign lane_o = lane_q;
  assign done_o = done_q;

  // R8: the done pulse never lasts two cycles
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: the engine is idle whenever done is shown
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_o);

endmodule

// File: rtl/pfe_addr_gen.sv
module pfe_addr_gen
  import pfe_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch_i,
  input  logic                mode_i,
  input  logic [ADDR_W-1:0]   base_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                pixel_adv_i,
  input  logic [1:0]          lane_i,
  output logic [ADDR_W-1:0]   addr_o
);

  logic [ADDR_W-1:0] pix_base_q;
  logic [ADDR_W-1:0] step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_base_q <= '0;
      step_q     <= '0;
    end else if (launch_i) begin
      pix_base_q <= base_i;
      step_q     <= ADDR_W'(pixel_step(mode_i, 32'(stride_i)));
    end else if (pixel_adv_i) begin
      pix_base_q <= pix_base_q + step_q;
    end
  end

  assign addr_o = pix_base_q + ADDR_W'(lane_i);

endmodule

// File: rtl/pfe_lane_mux.sv
module pfe_lane_mux
  import pfe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch_i,
  input  logic [23:0] color_i,
  input  logic [1:0]  lane_i,
  output logic [7:0]  data_o
);

  logic [23:0] color_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        color_q <= '0;
    else if (launch_i) color_q <= color_i;
  end

  assign data_o = color_lane(color_q, lane_i);

endmodule

// File: rtl/pixel_fill_engine.sv
module pixel_fill_engine
  import pfe_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 12,
  parameter int STRIDE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic [CNT_W-1:0]    pix_count_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [23:0]         color_i,
  output logic                wr_valid_o,
  input  logic                wr_ready_i,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [7:0]          wr_data_o,
  output logic                busy_o,
  output logic                done_o
);

  localparam int JOB_W = CNT_W + 2;

  // Named internal events
  logic       ev_launch;
  logic       ev_zero_start;
  logic       ev_accept;
  logic       ev_pixel_adv;
  logic       ev_last_accept;
  logic [1:0] lane;

  pfe_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .count_i       (pix_count_i),
    .ready_i       (wr_ready_i),
    .busy_o        (busy_o),
    .launch_o      (ev_launch),
    .zero_start_o  (ev_zero_start),
    .accept_o      (ev_accept),
    .pixel_adv_o   (ev_pixel_adv),
    .last_accept_o (ev_last_accept),
    .lane_o        (lane),
    .done_o        (done_o)
  );

  pfe_addr_gen #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch_i    (ev_launch),
    .mode_i      (mode_i),
    .base_i      (base_addr_i),
    .stride_i    (stride_i),
    .pixel_adv_i (ev_pixel_adv),
    .lane_i      (lane),
    .addr_o      (wr_addr_o)
  );

  pfe_lane_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (ev_launch),
    .color_i  (color_i),
    .lane_i   (lane),
    .data_o   (wr_data_o)
  );

  assign wr_valid_o = busy_o;

  // Byte bookkeeping for the total-count assertion
  logic [JOB_W-1:0] chk_bytes_q;
  logic [JOB_W-1:0] chk_expect_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_bytes_q  <= '0;
      chk_expect_q <= '0;
    end else if (start_i && !busy_o) begin
      chk_bytes_q  <= '0;
      chk_expect_q <= JOB_W'(pix_count_i) * JOB_W'(3);
    end else if (wr_valid_o && wr_ready_i) begin
      chk_bytes_q <= chk_bytes_q + JOB_W'(1);
    end
  end

  // R6: a stalled request holds address and data
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  // R1/R3: inside one pixel the address steps by one byte
  p_lane_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && !ev_last_accept && lane != 2'd2)
      |=> (wr_addr_o == $past(wr_addr_o) + ADDR_W'(1)));

  // R5: a zero-count start finishes at once with no write
  p_zero_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && pix_count_i == '0) |=> (done_o && !wr_valid_o));

  // R4: when done shows, exactly three bytes per pixel were taken
  p_byte_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (chk_bytes_q == chk_expect_q));

  // R7: a start during a job neither ends nor restarts it
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !ev_last_accept) |=> (busy_o && !done_o));

endmodule

// File: tb/pixel_fill_engine_bench.sv
module pixel_fill_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int CNT_W      = 6;
  localparam int STRIDE_W   = 10;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                start_i = 1'b0;
  logic                mode_i = 1'b0;
  logic [ADDR_W-1:0]   base_addr_i = '0;
  logic [CNT_W-1:0]    pix_count_i = '0;
  logic [STRIDE_W-1:0] stride_i = '0;
  logic [23:0]         color_i = '0;
  logic                wr_valid_o;
  logic                wr_ready_i = 1'b0;
  logic [ADDR_W-1:0]   wr_addr_o;
  logic [7:0]          wr_data_o;
  logic                busy_o;
  logic                done_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pixel_fill_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) u_pixel_fill_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .base_addr_i (base_addr_i),
    .pix_count_i (pix_count_i),
    .stride_i    (stride_i),
    .color_i     (color_i),
    .wr_valid_o  (wr_valid_o),
    .wr_ready_i  (wr_ready_i),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pick_ready(input int pat, output bit r);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    case (pat)
      0:       r = 1'b1;
      1:       r = cyc[0];
      default: r = lfsr[3] | lfsr[7];
    endcase
  endtask

  task automatic run_job(input bit mode, input int base, input int count,
                         input int stride, input int color, input int pat,
                         input bit poke);
    int total;
    int idx;
    int guard;
    bit prev_hold;
    bit poked;
    bit rdy;
    bit ok_end;
    logic [ADDR_W-1:0] prev_addr;
    logic [7:0] prev_data;
    longint step;
    longint exp_addr;
    longint exp_data;
    @(negedge clk);
    mode_i = mode;
    base_addr_i = ADDR_W'(base);
    pix_count_i = CNT_W'(count);
    stride_i = STRIDE_W'(stride);
    color_i = 24'(color);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R7: inputs changed after the start must not reach the job
    mode_i = ~mode;
    base_addr_i = ~base_addr_i;
    pix_count_i = pix_count_i + CNT_W'(3);
    stride_i = stride_i + STRIDE_W'(5);
    color_i = ~color_i;
    if (count == 0) begin
      check(done_o === 1'b1, "R5", "done after zero start", done_o, 1);
      check(wr_valid_o === 1'b0, "R5", "no write on zero count", wr_valid_o, 0);
      @(negedge clk);
      check(done_o === 1'b0, "R8", "done drop after zero job", done_o, 0);
      return;
    end
    total = 3 * count;
    step = mode ? 3 * longint'(stride) : 3;
    idx = 0;
    guard = 0;
    prev_hold = 0;
    poked = 0;
    ok_end = 0;
    prev_addr = '0;
    prev_data = '0;
    while (!ok_end && guard < 4000) begin
      if (start_i) start_i = 1'b0;
      if (prev_hold) begin
        check(wr_valid_o === 1'b1, "R6", "valid held", wr_valid_o, 1);
        check(wr_addr_o === prev_addr, "R6", "addr held", wr_addr_o, prev_addr);
        check(wr_data_o === prev_data, "R6", "data held", wr_data_o, prev_data);
      end
      check(busy_o === 1'b1 && wr_valid_o === 1'b1, "R4", "request present mid job",
            wr_valid_o, 1);
      pick_ready(pat, rdy);
      wr_ready_i = rdy;
      if (wr_valid_o && rdy) begin
        exp_addr = (longint'(base) + step * (idx / 3) + (idx % 3)) % (longint'(1) << ADDR_W);
        exp_data = (longint'(color) >> (8 * (2 - (idx % 3)))) & 8'hFF;
        check(longint'(wr_addr_o) == exp_addr, mode ? "R3" : "R1", "byte address",
              wr_addr_o, exp_addr);
        check(longint'(wr_data_o) == exp_data, "R2", "byte data", wr_data_o, exp_data);
        idx++;
      end
      prev_hold = wr_valid_o && !rdy;
      prev_addr = wr_addr_o;
      prev_data = wr_data_o;
      if (poke && !poked && idx == 1) begin
        start_i = 1'b1;
        poked = 1;
      end
      @(negedge clk);
      guard++;
      if (idx == total) begin
        check(done_o === 1'b1, "R8", "done after last byte", done_o, 1);
        check(wr_valid_o === 1'b0, "R4", "no byte beyond 3*count", wr_valid_o, 0);
        check(busy_o === 1'b0, "R8", "idle with done", busy_o, 0);
        wr_ready_i = 1'b1;
        @(negedge clk);
        check(done_o === 1'b0, "R8", "done one cycle only", done_o, 0);
        check(wr_valid_o === 1'b0, "R7", "no job from ignored start", wr_valid_o, 0);
        ok_end = 1;
      end else begin
        check(done_o === 1'b0, "R8", "no early done", done_o, 0);
      end
    end
    if (!ok_end) check(1'b0, "R4", "job did not end", idx, total);
    wr_ready_i = 1'b0;
    start_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int counts[6] = '{0, 1, 2, 3, 5, 7};
    int strides[3] = '{1, 5, 640};
    int bases[3] = '{16'h0100, 16'h2003, 16'hFFF8};
    repeat (3) @(negedge clk);
    // R9: reset values
    check(wr_valid_o === 1'b0, "R9", "valid in reset", wr_valid_o, 0);
    check(busy_o === 1'b0, "R9", "busy in reset", busy_o, 0);
    check(done_o === 1'b0, "R9", "done in reset", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(wr_valid_o === 1'b0 && done_o === 1'b0, "R9", "quiet after reset", wr_valid_o, 0);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 6; c++)
        for (int s = 0; s < 3; s++)
          for (int p = 0; p < 3; p++)
            run_job(m[0], bases[(c + s + p) % 3], counts[c], strides[s],
                    32'h00A1B2C3 ^ (c << 16) ^ (s << 8) ^ p, p, p == 2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule